// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

The block is a watchdog timer that software must service with a keyed two-write sequence. A free-running prescaler drives an 8-bit down counter. The prescaler is 13 bits wide and a 3-bit tap field picks which of its stages gives the counter its decrement step. If the counter runs out before software restarts it, the block either raises a one-cycle reset request or, when the timer-mode input is high, raises an interrupt and starts again by itself. In both cases a sticky timeout flag is set.

A small write/read register interface exposes four locations: control, load value and two key locations. A restart counts only if the first key write is directly followed by the second key write. Any other register write after the first key counts as a tamper and causes an immediate reset request. The counting clock is either every system clock cycle or a qualified enable from a slower oscillator domain. A change of that selection is only applied by the next valid restart.

Top module: `keyed_watchdog`

## Requirements
- R1: After any reset the control register reads E5h, the load register reads FFh, and `rst_req` and `irq` are low. Control layout: bits [7:5] tap, bits [4:3] read 0, bit 2 run, bit 1 timeout flag, bit 0 clock select. Location 0 is control, 1 is load, 2 is key 1 and 3 is key 2.
- R2: With counting enabled on every cycle, `rst_req` rises exactly (load+1)·2^(tap+5)+1 clock edges after the edge that accepts the second key write.
- R3: A valid restart consists of A5h written to location 2, with the very next register write being 5Ah to location 3. It reloads the counter from the load register and clears the prescaler, so the full timeout of R2 begins again.
- R4: After A5h has been written to location 2, if the next register write is anything other than 5Ah to location 3, `rst_req` is high in the cycle after that write. This applies in both modes.
- R5: A write of 5Ah to location 3 that does not directly follow the first key is ignored. The running timeout keeps its original expiry edge.
- R6: In watchdog mode (`timer_mode` = 0), an expiry drives `rst_req` high for exactly one cycle and sets the timeout flag (control bit 1).
- R7: In timer mode (`timer_mode` = 1), an expiry sets the flag and raises `irq`, and `rst_req` stays low. The counter reloads itself, so the next expiry follows (load+1)·2^(tap+5) edges later. Writing control with bit 1 = 0 clears the flag and `irq`. Writing 1 to bit 1 has no effect.
- R8: The timeout flag is cleared only by `por_n`. It survives a `sys_rst_n` reset, while the other control fields return to their reset values.
- R9: When the applied clock select is 1, the counter advances only in cycles where `osc_tick` is high. When it is 0, the counter advances every cycle. A newly written clock-select value is applied only when the next valid restart completes.
- R10: With the run bit at 0 the prescaler and counter hold. Setting run back to 1 resumes counting from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything including the flag |
| sys_rst_n | input | 1 | Other system reset, synchronous, active low; leaves the flag |
| osc_tick | input | 1 | One-cycle enable from the slow oscillator domain |
| timer_mode | input | 1 | 1: expiry raises an interrupt; 0: expiry requests reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write location |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read location |
| rd_data | output | 8 | Register read data (combinational) |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Interrupt request, held until the flag is cleared |

## Verification
The timeout is swept over every tap setting with several load values, and the edge count to `rst_req` is compared with the closed-form length. A single wrong bit in the tap decode or an off-by-one in the step pipeline changes the count. Key sequences are tried in three shapes: a clean pair, a first key followed by a foreign write or a wrong second key, and a lone second key in the middle of a count. Together these separate restart, tamper and ignore. The clock-select and run tests hold `osc_tick` low so that only the applied selection decides whether time passes. The timer-mode run measures two back-to-back intervals to show the automatic reload.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam int REG_W    = 8;
   localparam int BIT_RUN  = 2;
   localparam int BIT_FLAG = 1;
   localparam int BIT_SEL  = 0;

   localparam logic [REG_W-1:0] KEY_FIRST  = 8'hA5;
   localparam logic [REG_W-1:0] KEY_SECOND = 8'h5A;

   typedef enum logic [1:0] {
      LOC_CTRL = 2'd0,
      LOC_LOAD = 2'd1,
      LOC_KEY1 = 2'd2,
      LOC_KEY2 = 2'd3
   } wdk_loc_e;
endpackage

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
   parameter int TAP_W    = 3,
   parameter int PRE_BASE = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             advance,
   input  logic [TAP_W-1:0] tap,
   output logic             step
);
   localparam int N_TAPS = 2 ** TAP_W;
   localparam int PRE_W  = PRE_BASE + N_TAPS;

   logic [PRE_W-1:0]  pre_q;
   logic [PRE_W-1:0]  pre_nxt;
   logic [N_TAPS-1:0] carry_out;
   logic              step_q;

   assign pre_nxt = pre_q + PRE_W'(1);

   // one tap per stage: the step fires when that stage toggles
   for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
      assign carry_out[g] = pre_q[PRE_BASE+g] ^ pre_nxt[PRE_BASE+g];
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         pre_q  <= '0;
         step_q <= 1'b0;
      end else begin
         step_q <= advance && carry_out[tap];
         if (advance) pre_q <= pre_nxt;
      end
   end

   assign step = step_q;

   // R3
   pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
      clear |=> (pre_q == '0 && !step_q));

   // R10
   pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!advance && !clear) |=> $stable(pre_q));
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reload,
   input  logic             step,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign expire = step && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '1;
      end else if (reload || expire) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R2
   cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R7
   cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (expire && !reload) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int TAP_W = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             timer_mode,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   input  logic             expire,
   output logic [REG_W-1:0] rd_data,
   output logic [TAP_W-1:0] tap,
   output logic             run,
   output logic             clk_sel_act,
   output logic [CNT_W-1:0] load_val,
   output logic             feed,
   output logic             rst_req,
   output logic             irq
);
   localparam int TAP_LSB = REG_W - TAP_W;

   logic     sys_rst;
   wdk_loc_e wr_loc;
   wdk_loc_e rd_loc;
   logic     armed_q;
   logic     sel_pend_q;
   logic     flag_q;
   logic     key1_hit;
   logic     key2_hit;
   logic     abort;
   logic     ctrl_wr;
   logic     load_wr;
   logic     flag_clr;
   logic     timeout;

   assign sys_rst  = !por_n || !sys_rst_n;
   assign wr_loc   = wdk_loc_e'(wr_addr);
   assign rd_loc   = wdk_loc_e'(rd_addr);
   assign key1_hit = wr_en && wr_loc == LOC_KEY1 && wr_data == KEY_FIRST;
   assign key2_hit = wr_en && wr_loc == LOC_KEY2 && wr_data == KEY_SECOND;
   assign feed     = armed_q && key2_hit;
   assign abort    = armed_q && wr_en && !key2_hit;
   assign ctrl_wr  = wr_en && wr_loc == LOC_CTRL;
   assign load_wr  = wr_en && wr_loc == LOC_LOAD;
   assign flag_clr = ctrl_wr && !wr_data[BIT_FLAG];
   assign timeout  = expire && !feed;

   always_ff @(posedge clk) begin
      if (sys_rst) begin
         tap         <= '1;
         run         <= 1'b1;
         sel_pend_q  <= 1'b1;
         clk_sel_act <= 1'b1;
         load_val    <= '1;
         armed_q     <= 1'b0;
         rst_req     <= 1'b0;
         irq         <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            tap        <= wr_data[REG_W-1:TAP_LSB];
            run        <= wr_data[BIT_RUN];
            sel_pend_q <= wr_data[BIT_SEL];
         end
         if (load_wr) load_val <= wr_data[CNT_W-1:0];
         if (wr_en)   armed_q  <= !armed_q && key1_hit;
         if (feed)    clk_sel_act <= sel_pend_q;
         rst_req <= abort || (timeout && !timer_mode);
         if (timeout && timer_mode) irq <= 1'b1;
         else if (flag_clr)         irq <= 1'b0;
      end
   end

   // the flag only answers to power-on reset
   always_ff @(posedge clk) begin
      if (!por_n)                 flag_q <= 1'b0;
      else if (abort || timeout)  flag_q <= 1'b1;
      else if (flag_clr)          flag_q <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      case (rd_loc)
         LOC_CTRL: begin
            rd_data[REG_W-1:TAP_LSB] = tap;
            rd_data[BIT_RUN]         = run;
            rd_data[BIT_FLAG]        = flag_q;
            rd_data[BIT_SEL]         = sel_pend_q;
         end
         LOC_LOAD: rd_data[CNT_W-1:0] = load_val;
         default:  rd_data = '0;
      endcase
   end

   // R4
   tamper_rst_chk: assert property (@(posedge clk) disable iff (sys_rst)
      (armed_q && wr_en && !(wr_loc == LOC_KEY2 && wr_data == KEY_SECOND)) |=> rst_req);

   // R6
   rst_sets_flag_chk: assert property (@(posedge clk) disable iff (sys_rst)
      rst_req |-> flag_q);

   // R7
   irq_flag_chk: assert property (@(posedge clk) disable iff (sys_rst)
      irq |-> flag_q);

   // R9
   sel_apply_chk: assert property (@(posedge clk) disable iff (sys_rst)
      !feed |=> $stable(clk_sel_act));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdk_pkg::*;
#(
   parameter int TAP_W    = 3,
   parameter int PRE_BASE = 5,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             osc_tick,
   input  logic             timer_mode,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [REG_W-1:0] rd_data,
   output logic             rst_req,
   output logic             irq
);
   if (TAP_W < 1 || TAP_W > 5) begin : g_bad_tap
      $error("keyed_watchdog: TAP_W must fit control bits above the run bit");
   end
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
      $error("keyed_watchdog: CNT_W must fit the register width");
   end
   if (PRE_BASE < 1) begin : g_bad_base
      $error("keyed_watchdog: PRE_BASE must be at least 1");
   end

   logic             sys_rst;
   logic [TAP_W-1:0] tap;
   logic             run;
   logic             clk_sel_act;
   logic [CNT_W-1:0] load_val;
   logic             feed;
   logic             advance;
   logic             step;
   logic             expire;

   assign sys_rst = !por_n || !sys_rst_n;
   assign advance = run && (clk_sel_act ? osc_tick : 1'b1);

   wdk_regs #(.CNT_W(CNT_W), .TAP_W(TAP_W)) regs_i (
      .clk        (clk),
      .por_n      (por_n),
      .sys_rst_n  (sys_rst_n),
      .timer_mode (timer_mode),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .expire     (expire),
      .rd_data    (rd_data),
      .tap        (tap),
      .run        (run),
      .clk_sel_act(clk_sel_act),
      .load_val   (load_val),
      .feed       (feed),
      .rst_req    (rst_req),
      .irq        (irq)
   );

   wdk_prescale #(.TAP_W(TAP_W), .PRE_BASE(PRE_BASE)) pre_i (
      .clk    (clk),
      .rst    (sys_rst),
      .clear  (feed),
      .advance(advance),
      .tap    (tap),
      .step   (step)
   );

   wdk_count #(.CNT_W(CNT_W)) cnt_i (
      .clk     (clk),
      .rst     (sys_rst),
      .reload  (feed),
      .step    (step),
      .load_val(load_val),
      .expire  (expire)
   );

   // R6
   rst_mode_chk: assert property (@(posedge clk) disable iff (sys_rst)
      (rst_req && !$past(rst_req)) |=> !rst_req);
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic       osc_tick = 1'b1;
   logic       timer_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       rst_req;
   logic       irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   keyed_watchdog dut_i (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .osc_tick(osc_tick),
      .timer_mode(timer_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic feed();
      do_write(2'd2, 8'hA5);
      do_write(2'd3, 8'h5A);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic measure(input int limit, input bit use_irq,
                          output int n, output bit hit, output bit saw_rst);
      n = 0; hit = 1'b0; saw_rst = 1'b0;
      while (!hit && n < limit) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (rst_req) saw_rst = 1'b1;
         if (use_irq ? irq : rst_req) hit = 1'b1;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R2: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n; bit hit; bit sr; logic [7:0] v; int ex;
      repeat (3) @(posedge clk);
      #1;
      check(rst_req == 1'b0 && irq == 1'b0, "R1 outputs in reset", rst_req, 0);
      por_n = 1'b1; sys_rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); check(v == 8'hE5, "R1 control reset", v, 8'hE5);
      rd(2'd1, v); check(v == 8'hFF, "R1 load reset", v, 8'hFF);

      // R2 and R6: sweep every tap with several loads
      for (int t = 0; t < 8; t++) begin
         for (int l = 0; l < 3; l++) begin
            ex = (l + 1) * (1 << (t + 5)) + 1;
            do_write(2'd0, {t[2:0], 2'b00, 1'b1, 1'b0, 1'b1});
            do_write(2'd1, l[7:0]);
            feed();
            measure(ex + 5, 1'b0, n, hit, sr);
            check(hit && n == ex, "R2 timeout length", n, ex);
            rd(2'd0, v); check(v[1] == 1'b1, "R6 flag set on expiry", v[1], 1);
            @(negedge clk); check(rst_req == 1'b0, "R6 single-cycle request", rst_req, 0);
         end
      end

      // R4: foreign write after first key
      do_write(2'd2, 8'hA5); do_write(2'd1, 8'h03);
      @(negedge clk); check(rst_req == 1'b1, "R4 tamper by load write", rst_req, 1);
      @(negedge clk); check(rst_req == 1'b0, "R4 tamper pulse ends", rst_req, 0);
      do_write(2'd2, 8'hA5); do_write(2'd3, 8'h00);
      @(negedge clk); check(rst_req == 1'b1, "R4 tamper by wrong key", rst_req, 1);

      // R5: lone second key keeps original expiry (tap0 load3 -> 129)
      do_write(2'd0, 8'h05); do_write(2'd1, 8'h03);
      feed();
      repeat (60) @(posedge clk);
      #1; do_write(2'd3, 8'h5A);
      measure(200, 1'b0, n, hit, sr);
      check(hit && n == 68, "R5 lone key ignored", n, 68);

      // R3: mid-count restart gives a full new interval
      feed();
      repeat (60) @(posedge clk);
      #1; feed();
      measure(200, 1'b0, n, hit, sr);
      check(hit && n == 129, "R3 restart reloads", n, 129);

      // R9: clock select
      do_write(2'd1, 8'h00);
      osc_tick = 1'b0;
      feed();
      measure(200, 1'b0, n, hit, sr);
      check(!hit, "R9 slow clock gated", hit, 0);
      do_write(2'd0, 8'h04);
      measure(200, 1'b0, n, hit, sr);
      check(!hit, "R9 select not applied without feed", hit, 0);
      feed();
      measure(200, 1'b0, n, hit, sr);
      check(hit && n == 33, "R9 select applied after feed", n, 33);
      osc_tick = 1'b1;

      // R10: run bit
      do_write(2'd0, 8'h00);
      feed();
      measure(200, 1'b0, n, hit, sr);
      check(!hit, "R10 halted while run clear", hit, 0);
      do_write(2'd0, 8'h04);
      measure(200, 1'b0, n, hit, sr);
      check(hit && n == 33, "R10 resumes from held state", n, 33);

      // R7: timer mode, two intervals (tap0 load1 -> 65 then 64)
      timer_mode = 1'b1;
      do_write(2'd1, 8'h01);
      feed();
      measure(200, 1'b1, n, hit, sr);
      check(hit && n == 65, "R7 first interrupt", n, 65);
      check(!sr, "R7 no reset request", sr, 0);
      rd(2'd0, v); check(v[1] == 1'b1, "R7 flag set", v[1], 1);
      do_write(2'd0, 8'h04);
      @(negedge clk); check(irq == 1'b0, "R7 irq cleared with flag", irq, 0);
      measure(200, 1'b1, n, hit, sr);
      check(hit && n == 63, "R7 auto reload interval", n, 63);
      check(!sr, "R7 no reset request second", sr, 0);

      // R8: flag kept by system reset, cleared by power-on
      timer_mode = 1'b0;
      do_write(2'd0, 8'h04);
      do_write(2'd2, 8'hA5); do_write(2'd0, 8'h05);
      @(negedge clk); check(rst_req == 1'b1, "R4 tamper by control write", rst_req, 1);
      rd(2'd0, v); check(v == 8'h07, "R8 flag after tamper", v, 8'h07);
      sys_rst_n = 1'b0; repeat (2) @(negedge clk); sys_rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); check(v == 8'hE7, "R8 flag survives system reset", v, 8'hE7);
      por_n = 1'b0; repeat (2) @(negedge clk); por_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); check(v == 8'hE5, "R8 flag cleared by power-on", v, 8'hE5);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule